// File: doc/BRIEF.md
# Producer–Consumer Line Lead Tracker

This block sits between two channels that share external memory: a producer channel that writes sensor lines into a frame, and a consumer channel that reads those lines back as horizontal rows of square tiles for compression. It counts the lines the producer has committed and the lines the consumer has already taken. A consumer request for the next tile row is granted only when the producer is far enough ahead that every line the row needs is already in memory.

The required lead depends on the scan mode. In normal mode, every tile row needs the tile height plus the overlap lines below it. In line-scan mode, a frame is built from sub-frames of a fixed number of tile rows. The last tile row of each sub-frame needs no overlap lines, because the next sub-frame is unrelated.

The block also tracks how many transfer blocks sit in the small on-chip buffer in front of each channel. It raises full and empty flags for each buffer. If the producer tries to write into a full buffer, a sticky error flag is set. A frame-start pulse restarts the line counters, the tile-row position and both buffer counters.

Top module: `lead_tracker`

## Requirements
- R1: A `frame_start` pulse clears, at the next clock edge, both line counters, the sub-frame row position and both occupancy counts. It takes priority over any line, request or block event in the same cycle, and `row_grant` is low in the following cycle. It does not clear `overrun_err`.
- R2: Each cycle with `line_done` high adds one to `prod_lines`. The count saturates at 2^LINE_W−1.
- R3: In normal mode (`linescan` = 0), `row_grant` is high in the cycle after a `row_req` exactly when `prod_lines >= cons_lines + TILE_H + OVERLAP` held in the request cycle (16 + 4 = 20 lines by default).
- R4: Each granted row adds TILE_H (16) to `cons_lines` at the same edge that raises `row_grant`.
- R5: In line-scan mode (`linescan` = 1), the required lead is TILE_H (16) lines for the last row of each sub-frame, which is the row whose index within the frame, modulo SUB_ROWS, equals SUB_ROWS−1. All other rows still need TILE_H + OVERLAP lines. Tile-row indices count granted rows from 0 since the last frame start.
- R6: Each buffer count (`prod_occ`, `cons_occ`) goes up by one on a write and down by one on a read. A write and a read in the same cycle leave it unchanged. It stays within 0 to BLOCKS (4).
- R7: A full flag is high exactly when its count equals BLOCKS. An empty flag is high exactly when its count is 0.
- R8: A producer block write while `prod_full` is high and no drain happens in the same cycle sets `overrun_err` at the next edge. The flag then stays high until a cycle with `err_clr`. A new overrun in the same cycle as `err_clr` wins.
- R9: On the consumer side, a fill while full and a take while empty have no effect on `cons_occ` and never set `overrun_err`.
- R10: `row_grant` is low in any cycle that follows a cycle without `row_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Frame start pulse |
| linescan | input | 1 | 0 = normal mode, 1 = line-scan mode |
| line_done | input | 1 | Producer committed one line to memory |
| row_req | input | 1 | Consumer asks for its next tile row |
| row_grant | output | 1 | Tile row granted (registered, one cycle after the request) |
| prod_lines | output | LINE_W | Lines committed by the producer this frame |
| cons_lines | output | LINE_W | Lines consumed by granted tile rows this frame |
| prod_wr | input | 1 | Producer writes a block into its buffer |
| prod_drain | input | 1 | Memory takes a block from the producer buffer |
| cons_fill | input | 1 | Memory puts a block into the consumer buffer |
| cons_take | input | 1 | Consumer takes a block from its buffer |
| prod_occ | output | OCC_W | Producer buffer occupancy in blocks |
| cons_occ | output | OCC_W | Consumer buffer occupancy in blocks |
| prod_full | output | 1 | Producer buffer holds BLOCKS blocks |
| prod_empty | output | 1 | Producer buffer is empty |
| cons_full | output | 1 | Consumer buffer holds BLOCKS blocks |
| cons_empty | output | 1 | Consumer buffer is empty |
| err_clr | input | 1 | Clears the overrun flag |
| overrun_err | output | 1 | Sticky producer overrun flag |

## Verification
All results are due one clock edge after the stimulus. The line counts, buffer counts, `row_grant` and `overrun_err` change at the edge that samples the inputs, and the flags follow the counts in the same cycle. The bench drives every input just after a falling edge. It then waits one full period and compares every output at the next falling edge against a model that it advances by one step per cycle from the rules in the requirements. Lead thresholds are probed one line below and exactly at the required value for every row position, in both modes.

// File: rtl/lt_pkg.sv
package lt_pkg;
  typedef enum logic {
    MODE_NORMAL   = 1'b0,
    MODE_LINESCAN = 1'b1
  } scan_mode_e;
endpackage

// File: rtl/lt_occupancy.sv
module lt_occupancy #(
  parameter int BLOCKS = 4,
  localparam int OCC_W = $clog2(BLOCKS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  input  logic             dec,
  output logic [OCC_W-1:0] occ,
  output logic             full,
  output logic             empty
);
  localparam logic [OCC_W-1:0] MAXV = OCC_W'(BLOCKS);

  logic [OCC_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (inc && !dec && cnt_q != MAXV) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (dec && !inc && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign occ   = cnt_q;
  assign full  = (cnt_q == MAXV);
  assign empty = (cnt_q == '0);
endmodule

// File: rtl/lt_line_track.sv
module lt_line_track
  import lt_pkg::*;
#(
  parameter int LINE_W   = 14,
  parameter int TILE_H   = 16,
  parameter int OVERLAP  = 4,
  parameter int SUB_ROWS = 4,
  localparam int SUB_W   = (SUB_ROWS > 1) ? $clog2(SUB_ROWS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  scan_mode_e        mode,
  input  logic              line_done,
  input  logic              row_req,
  output logic              row_grant,
  output logic [LINE_W-1:0] prod_lines,
  output logic [LINE_W-1:0] cons_lines
);
  localparam logic [LINE_W:0]   NEED_FULL = (LINE_W+1)'(TILE_H + OVERLAP);
  localparam logic [LINE_W:0]   NEED_EDGE = (LINE_W+1)'(TILE_H);
  localparam logic [SUB_W-1:0]  LAST_ROW  = SUB_W'(SUB_ROWS - 1);
  localparam logic [LINE_W-1:0] STEP      = LINE_W'(TILE_H);

  logic [LINE_W-1:0] prod_q, cons_q;
  logic [SUB_W-1:0]  sub_q;
  logic              grant_q;
  logic [LINE_W:0]   need;
  logic              lead_ok;
  logic              take_row;

  always_comb begin
    need = (mode == MODE_LINESCAN && sub_q == LAST_ROW) ? NEED_EDGE : NEED_FULL;
    lead_ok  = {1'b0, prod_q} >= ({1'b0, cons_q} + need);
    take_row = row_req && lead_ok && !frame_start;
  end

  always_ff @(posedge clk) begin
    if (rst || frame_start) begin
      prod_q <= '0;
    end else if (line_done && prod_q != '1) begin
      prod_q <= prod_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || frame_start) begin
      cons_q  <= '0;
      sub_q   <= '0;
      grant_q <= 1'b0;
    end else begin
      grant_q <= take_row;
      if (take_row) begin
        cons_q <= cons_q + STEP;
        sub_q  <= (sub_q == LAST_ROW) ? '0 : sub_q + 1'b1;
      end
    end
  end

  assign row_grant  = grant_q;
  assign prod_lines = prod_q;
  assign cons_lines = cons_q;
endmodule

// File: rtl/lead_tracker.sv
module lead_tracker
  import lt_pkg::*;
#(
  parameter int LINE_W   = 14,
  parameter int TILE_H   = 16,
  parameter int OVERLAP  = 4,
  parameter int SUB_ROWS = 4,
  parameter int BLOCKS   = 4,
  localparam int OCC_W   = $clog2(BLOCKS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              linescan,
  input  logic              line_done,
  input  logic              row_req,
  output logic              row_grant,
  output logic [LINE_W-1:0] prod_lines,
  output logic [LINE_W-1:0] cons_lines,
  input  logic              prod_wr,
  input  logic              prod_drain,
  input  logic              cons_fill,
  input  logic              cons_take,
  output logic [OCC_W-1:0]  prod_occ,
  output logic [OCC_W-1:0]  cons_occ,
  output logic              prod_full,
  output logic              prod_empty,
  output logic              cons_full,
  output logic              cons_empty,
  input  logic              err_clr,
  output logic              overrun_err
);
  scan_mode_e mode;
  logic       err_q;
  logic       overrun_now;

  assign mode = linescan ? MODE_LINESCAN : MODE_NORMAL;

  lt_line_track #(
    .LINE_W(LINE_W), .TILE_H(TILE_H), .OVERLAP(OVERLAP), .SUB_ROWS(SUB_ROWS)
  ) u_lines (
    .clk(clk), .rst(rst), .frame_start(frame_start), .mode(mode),
    .line_done(line_done), .row_req(row_req), .row_grant(row_grant),
    .prod_lines(prod_lines), .cons_lines(cons_lines)
  );

  lt_occupancy #(.BLOCKS(BLOCKS)) u_prod_buf (
    .clk(clk), .rst(rst), .clr(frame_start), .inc(prod_wr), .dec(prod_drain),
    .occ(prod_occ), .full(prod_full), .empty(prod_empty)
  );

  lt_occupancy #(.BLOCKS(BLOCKS)) u_cons_buf (
    .clk(clk), .rst(rst), .clr(frame_start), .inc(cons_fill), .dec(cons_take),
    .occ(cons_occ), .full(cons_full), .empty(cons_empty)
  );

  assign overrun_now = prod_wr && prod_full && !prod_drain;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= 1'b0;
    end else if (overrun_now) begin
      err_q <= 1'b1;
    end else if (err_clr) begin
      err_q <= 1'b0;
    end
  end

  assign overrun_err = err_q;
endmodule

// File: rtl/lt_checks.sv
module lt_checks #(
  parameter int LINE_W = 14,
  parameter int TILE_H = 16,
  parameter int BLOCKS = 4,
  localparam int OCC_W = $clog2(BLOCKS + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_start,
  input logic              row_req,
  input logic              row_grant,
  input logic [LINE_W-1:0] prod_lines,
  input logic [LINE_W-1:0] cons_lines,
  input logic              prod_wr,
  input logic              prod_drain,
  input logic [OCC_W-1:0]  prod_occ,
  input logic [OCC_W-1:0]  cons_occ,
  input logic              err_clr,
  input logic              overrun_err
);
  // R1: a frame start empties the counters one edge later
  assert_frame_clear_R1: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (prod_lines == '0 && cons_lines == '0 && prod_occ == '0 && cons_occ == '0));

  // R3: a grant is never given with less than one tile height of lead
  assert_grant_lead_R3: assert property (@(posedge clk) disable iff (rst)
    row_grant |-> ({1'b0, $past(prod_lines)} >= {1'b0, $past(cons_lines)} + (LINE_W+1)'(TILE_H)));

  // R4: each grant moves the consumer by one tile height
  assert_cons_step_R4: assert property (@(posedge clk) disable iff (rst)
    row_grant |-> (cons_lines == $past(cons_lines) + LINE_W'(TILE_H)));

  // R6: occupancy never exceeds the buffer depth
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    (prod_occ <= OCC_W'(BLOCKS)) && (cons_occ <= OCC_W'(BLOCKS)));

  // R6: a write and a drain together leave the count alone
  assert_balanced_R6: assert property (@(posedge clk) disable iff (rst)
    (prod_wr && prod_drain && !frame_start) |=> $stable(prod_occ));

  // R8: the error flag holds until cleared
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (overrun_err && !err_clr) |=> overrun_err);

  // R10: no request, no grant
  assert_no_idle_grant_R10: assert property (@(posedge clk) disable iff (rst)
    !row_req |=> !row_grant);
endmodule

bind lead_tracker lt_checks #(
  .LINE_W(LINE_W), .TILE_H(TILE_H), .BLOCKS(BLOCKS)
) u_checks (
  .clk(clk), .rst(rst), .frame_start(frame_start), .row_req(row_req),
  .row_grant(row_grant), .prod_lines(prod_lines), .cons_lines(cons_lines),
  .prod_wr(prod_wr), .prod_drain(prod_drain), .prod_occ(prod_occ),
  .cons_occ(cons_occ), .err_clr(err_clr), .overrun_err(overrun_err)
);

// File: tb/tb_lead_tracker.sv
module tb_lead_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int LINE_W = 14;
  localparam int TILE_H = 16;
  localparam int OVERLAP = 4;
  localparam int SUB_ROWS = 4;
  localparam int BLOCKS = 4;
  localparam int OCC_W = $clog2(BLOCKS + 1);
  localparam int LMAX = (1 << LINE_W) - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic frame_start = 0, linescan = 0, line_done = 0, row_req = 0;
  logic prod_wr = 0, prod_drain = 0, cons_fill = 0, cons_take = 0, err_clr = 0;
  logic row_grant, prod_full, prod_empty, cons_full, cons_empty, overrun_err;
  logic [LINE_W-1:0] prod_lines, cons_lines;
  logic [OCC_W-1:0] prod_occ, cons_occ;

  int checks = 0, fails = 0;
  int m_prod = 0, m_cons = 0, m_sub = 0, m_pocc = 0, m_cocc = 0;
  int m_grant = 0, m_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lead_tracker #(.LINE_W(LINE_W), .TILE_H(TILE_H), .OVERLAP(OVERLAP),
                 .SUB_ROWS(SUB_ROWS), .BLOCKS(BLOCKS)) dut (.*);

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int need_now(input int ls);
    return (ls != 0 && m_sub == SUB_ROWS-1) ? TILE_H : TILE_H + OVERLAP;
  endfunction

  // Apply one cycle of inputs, advance the model, compare every output.
  task automatic cyc(input int fs, input int ls, input int ld, input int rq,
                     input int pw, input int pd, input int cf, input int ct,
                     input int ec);
    int ovr, ok, c_ign;
    frame_start = fs[0]; linescan = ls[0]; line_done = ld[0]; row_req = rq[0];
    prod_wr = pw[0]; prod_drain = pd[0]; cons_fill = cf[0]; cons_take = ct[0];
    err_clr = ec[0];
    ovr   = (pw != 0 && pd == 0 && m_pocc == BLOCKS) ? 1 : 0;
    c_ign = ((cf != 0 && ct == 0 && m_cocc == BLOCKS) ||
             (ct != 0 && cf == 0 && m_cocc == 0)) ? 1 : 0;
    ok = (m_prod >= m_cons + need_now(ls)) ? 1 : 0;
    if (fs != 0) begin
      m_prod = 0; m_cons = 0; m_sub = 0; m_pocc = 0; m_cocc = 0; m_grant = 0;
    end else begin
      m_grant = (rq != 0 && ok != 0) ? 1 : 0;
      if (m_grant != 0) begin
        m_cons += TILE_H;
        m_sub = (m_sub == SUB_ROWS-1) ? 0 : m_sub + 1;
      end
      if (ld != 0 && m_prod < LMAX) m_prod++;
      if (pw != 0 && pd == 0 && m_pocc < BLOCKS) m_pocc++;
      else if (pd != 0 && pw == 0 && m_pocc > 0) m_pocc--;
      if (cf != 0 && ct == 0 && m_cocc < BLOCKS) m_cocc++;
      else if (ct != 0 && cf == 0 && m_cocc > 0) m_cocc--;
    end
    if (ovr != 0) m_err = 1;
    else if (ec != 0) m_err = 0;
    @(negedge clk);
    frame_start = 0; line_done = 0; row_req = 0; prod_wr = 0; prod_drain = 0;
    cons_fill = 0; cons_take = 0; err_clr = 0;
    check(fs != 0 ? "R1 row_grant" : (rq == 0 ? "R10 row_grant" :
          (ls != 0 ? "R5 row_grant" : "R3 row_grant")), int'(row_grant), m_grant);
    check(fs != 0 ? "R1 prod_lines" : "R2 prod_lines", int'(prod_lines), m_prod);
    check(fs != 0 ? "R1 cons_lines" : "R4 cons_lines", int'(cons_lines), m_cons);
    check(fs != 0 ? "R1 prod_occ" : "R6 prod_occ", int'(prod_occ), m_pocc);
    check(fs != 0 ? "R1 cons_occ" : (c_ign != 0 ? "R9 cons_occ" : "R6 cons_occ"),
          int'(cons_occ), m_cocc);
    check("R7 prod_full", int'(prod_full), m_pocc == BLOCKS ? 1 : 0);
    check("R7 prod_empty", int'(prod_empty), m_pocc == 0 ? 1 : 0);
    check("R7 cons_full", int'(cons_full), m_cocc == BLOCKS ? 1 : 0);
    check("R7 cons_empty", int'(cons_empty), m_cocc == 0 ? 1 : 0);
    check(c_ign != 0 ? "R9 overrun_err" : "R8 overrun_err", int'(overrun_err), m_err);
  endtask

  task automatic lines(input int n, input int ls);
    for (int i = 0; i < n; i++) cyc(0, ls, 1, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 0;
    // reset state (R1)
    check("R1 reset prod_lines", int'(prod_lines), 0);
    check("R1 reset grant", int'(row_grant), 0);
    check("R1 reset err", int'(overrun_err), 0);

    // R3: threshold sweep in normal mode, first and second rows
    for (int l = 0; l <= 40; l++) begin
      cyc(1, 0, 0, 0, 0, 0, 0, 0, 0);
      lines(l, 0);
      cyc(0, 0, 0, 1, 0, 0, 0, 0, 0);
      cyc(0, 0, 0, 1, 0, 0, 0, 0, 0);
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
    end

    // R5 (and R3 for comparison): per row, one line short then exact lead
    for (int ls = 0; ls < 2; ls++) begin
      cyc(1, ls, 0, 0, 0, 0, 0, 0, 0);
      for (int r = 0; r < 2 * SUB_ROWS + 1; r++) begin
        while (m_prod < m_cons + need_now(ls) - 1) lines(1, ls);
        cyc(0, ls, 0, 1, 0, 0, 0, 0, 0);
        lines(1, ls);
        cyc(0, ls, 0, 1, 0, 0, 0, 0, 0);
      end
    end

    // R1: frame start wins over same-cycle line, request and block events
    lines(30, 0);
    cyc(0, 0, 0, 0, 1, 0, 1, 0, 0);
    cyc(1, 0, 1, 1, 1, 0, 1, 0, 0);
    cyc(0, 0, 0, 1, 0, 0, 0, 0, 0);

    // R6, R7, R8, R9: every start level with every event pair
    for (int s = 0; s <= BLOCKS; s++) begin
      for (int e = 0; e < 4; e++) begin
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 1);
        for (int k = 0; k < s; k++) cyc(0, 0, 0, 0, 1, 0, 1, 0, 0);
        cyc(0, 0, 0, 0, e & 1, e >> 1, e & 1, e >> 1, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
      end
    end

    // R8: sticky through frame start, cleared by err_clr, overrun beats clear
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 1);
    for (int k = 0; k < BLOCKS; k++) cyc(0, 0, 0, 0, 1, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1);
    for (int k = 0; k < BLOCKS; k++) cyc(0, 0, 0, 0, 1, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1);

    // R2: saturation of the producer line count
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 0);
    lines(LMAX + 3, 0);
    cyc(0, 0, 0, 1, 0, 0, 0, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule